// File: doc/BRIEF.md
# I2C Slave Dual-Address Recognizer

This block is the address front end of an I2C slave. It watches already-synchronized SCL and SDA lines for a START condition and shifts in the first byte after it. It then decides whether to acknowledge that byte. Two programmable addresses are checked in parallel. The primary one can be switched into an expanded mode, in which only its upper four bits are compared and the all-zero general-call address is also accepted. The secondary one is always compared on all seven bits.

When either address matches, the block pulls SDA low for the ninth clock. After it lets SDA go again, it gives a one-cycle pulse. Together with that pulse it latches which address was hit, whether the hit was a general call, and the read/write bit that came with the address. A byte that matches neither address leaves the bus untouched, and the block then sleeps until the next START. Software programs both addresses through a small synchronous register port.

Top module: `i2c_dual_addr_slave`

## Requirements
- R1: Register select 0 is the primary register. Its bits 7:1 hold a 7-bit address and its bit 0 enables expanded mode. A write to it stores all 8 bits, and a read returns them unchanged.
- R2: Register select 1 is the secondary register. A write to it stores bits 7:1, and a read returns those bits with bit 0 always 0.
- R3: Reset clears both registers to 0, so expanded mode is off after reset.
- R4: With expanded mode off, the primary address matches when received byte bits 7:1 equal primary bits 7:1.
- R5: With expanded mode on, the primary address matches when received bits 7:4 equal primary bits 7:4. Received bits 3:1 are ignored.
- R6: With expanded mode on, a received byte whose bits 7:1 are all zero is accepted as a general call and sets matchGenCall. With expanded mode off, that byte is not accepted unless one of the programmed addresses is itself zero.
- R7: The secondary address always matches on all 7 bits, whatever the mode. A match on either address causes an acknowledge. matchSecondary is 1 only when the secondary address matched and neither the primary address nor the general call did.
- R8: Bit 0 of the received byte (1 = read) never takes part in the comparison. It is latched into matchRw on a match.
- R9: Bits are sampled on rising SCL, MSB first. On a match, sdaOe (1 = pull SDA low) rises after the SCL falling edge that follows the eighth rising edge. It stays high through the ninth SCL high phase and falls after the ninth falling edge.
- R10: One cycle after sdaOe is released, matchPulse is high for exactly one cycle. matchSecondary, matchGenCall and matchRw then hold their values until the next match.
- R11: A START (SDA falling while SCL is high) aborts any address phase and restarts bit collection. A STOP (SDA rising while SCL is high) aborts and returns to idle. Neither produces an acknowledge or a pulse.
- R12: A non-matching byte gives no acknowledge and no pulse. Later SCL clocks are ignored until the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Synchronized SCL line level |
| sdaIn | input | 1 | Synchronized SDA line level |
| sdaOe | output | 1 | 1 = drive SDA low (open-drain enable) |
| regSel | input | 1 | Register select: 0 primary, 1 secondary |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Read data of the selected register |
| matchPulse | output | 1 | One-cycle pulse after an acknowledged address |
| matchSecondary | output | 1 | Last match was on the secondary address only |
| matchGenCall | output | 1 | Last match was a general call |
| matchRw | output | 1 | Read/write bit of the last matched byte |

## Verification
A wrong bit count or a corrupted shift register shows at the ports within one address byte. Either an acknowledge appears on the wrong byte or none appears on the right one, and this is visible during the ninth SCL clock. A control state that does not return to idle after a mismatch or a STOP shows up as a stray acknowledge or an extra matchPulse on the next bytes. Wrong compare masking in expanded mode, or wrong flag priority, shows up in the flags that are latched one cycle after SDA is released.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic shiftEn;    // shift one received bit in
    logic clrCnt;     // restart bit counter
    logic latchMatch; // capture match flags and pulse
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_WAITFALL,
    ST_ACKLOW,
    ST_ACKHIGH
  } addrState_t;
endpackage

// File: rtl/i2c_bus_edges.sv
module i2c_bus_edges (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclIn;
      sdaPrev <= sdaIn;
    end
  end

  assign sclRise  = sclIn & ~sclPrev;
  assign sclFall  = ~sclIn & sclPrev;
  assign startDet = sclIn & sclPrev & sdaPrev & ~sdaIn;
  assign stopDet  = sclIn & sclPrev & ~sdaPrev & sdaIn;
endmodule

// File: rtl/i2c_addr_dp.sv
module i2c_addr_dp
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EXP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              regWe,
  input  logic [ADDR_W:0]   regWdata,
  output logic [ADDR_W:0]   regRdata,
  input  logic              sdaIn,
  input  ctrlStrobes_t      strobes,
  output logic              lastBit,
  output logic              anyMatch,
  output logic              matchPulse,
  output logic              matchSecondary,
  output logic              matchGenCall,
  output logic              matchRw
);
  localparam int CNT_W = $clog2(ADDR_W + 1);
  localparam logic [ADDR_W-1:0] EXP_MASK =
    {{EXP_W{1'b1}}, {(ADDR_W - EXP_W){1'b0}}};
  localparam logic [ADDR_W-1:0] FULL_MASK = '1;

  logic [ADDR_W:0]   priReg;
  logic [ADDR_W-1:0] secReg;
  logic [ADDR_W:0]   shiftReg;
  logic [CNT_W-1:0]  bitCnt;

  // register port
  always_ff @(posedge clk) begin
    if (!rstN) begin
      priReg <= '0;
      secReg <= '0;
    end else if (regWe) begin
      if (regSel) secReg <= regWdata[ADDR_W:1];
      else        priReg <= regWdata;
    end
  end

  assign regRdata = regSel ? {secReg, 1'b0} : priReg;

  // address shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strobes.clrCnt) begin
      bitCnt   <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= {shiftReg[ADDR_W-1:0], sdaIn};
      bitCnt   <= bitCnt + 1'b1;
    end
  end

  assign lastBit = (bitCnt == CNT_W'(ADDR_W));

  // comparators
  logic [ADDR_W-1:0] rxAddr, priMask;
  logic priHit, secHit, genHit, expEn;

  assign expEn   = priReg[0];
  assign rxAddr  = shiftReg[ADDR_W:1];
  assign priMask = expEn ? EXP_MASK : FULL_MASK;
  assign priHit  = ((rxAddr ^ priReg[ADDR_W:1]) & priMask) == '0;
  assign secHit  = (rxAddr == secReg);
  assign genHit  = expEn && (rxAddr == '0);
  assign anyMatch = priHit | secHit | genHit;

  // result capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchPulse     <= 1'b0;
      matchSecondary <= 1'b0;
      matchGenCall   <= 1'b0;
      matchRw        <= 1'b0;
    end else begin
      matchPulse <= strobes.latchMatch;
      if (strobes.latchMatch) begin
        matchSecondary <= secHit & ~priHit & ~genHit;
        matchGenCall   <= genHit;
        matchRw        <= shiftReg[0];
      end
    end
  end
endmodule

// File: rtl/i2c_addr_ctrl.sv
module i2c_addr_ctrl
  import i2c_addr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclRise,
  input  logic         sclFall,
  input  logic         startDet,
  input  logic         stopDet,
  input  logic         lastBit,
  input  logic         anyMatch,
  output ctrlStrobes_t strobes,
  output logic         sdaOe
);
  addrState_t state, stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strobes  = '0;
    if (startDet) begin
      stateNxt       = ST_SHIFT;
      strobes.clrCnt = 1'b1;
    end else if (stopDet) begin
      stateNxt = ST_IDLE;
    end else begin
      unique case (state)
        ST_SHIFT: if (sclRise) begin
          strobes.shiftEn = 1'b1;
          if (lastBit) stateNxt = ST_WAITFALL;
        end
        ST_WAITFALL: if (sclFall) stateNxt = anyMatch ? ST_ACKLOW : ST_IDLE;
        ST_ACKLOW:   if (sclRise) stateNxt = ST_ACKHIGH;
        ST_ACKHIGH:  if (sclFall) begin
          stateNxt           = ST_IDLE;
          strobes.latchMatch = 1'b1;
        end
        default: stateNxt = state;
      endcase
    end
  end

  assign sdaOe = (state == ST_ACKLOW) || (state == ST_ACKHIGH);
endmodule

// File: rtl/i2c_dual_addr_slave.sv
module i2c_dual_addr_slave
  import i2c_addr_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int EXP_W  = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            sclIn,
  input  logic            sdaIn,
  output logic            sdaOe,
  input  logic            regSel,
  input  logic            regWe,
  input  logic [ADDR_W:0] regWdata,
  output logic [ADDR_W:0] regRdata,
  output logic            matchPulse,
  output logic            matchSecondary,
  output logic            matchGenCall,
  output logic            matchRw
);
  logic sclRise, sclFall, startDet, stopDet, lastBit, anyMatch;
  ctrlStrobes_t strobes;

  i2c_bus_edges uEdges (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_addr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .lastBit(lastBit),
    .anyMatch(anyMatch), .strobes(strobes), .sdaOe(sdaOe)
  );

  i2c_addr_dp #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) uDp (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .sdaIn(sdaIn),
    .strobes(strobes), .lastBit(lastBit), .anyMatch(anyMatch),
    .matchPulse(matchPulse), .matchSecondary(matchSecondary),
    .matchGenCall(matchGenCall), .matchRw(matchRw)
  );
endmodule

// File: rtl/i2c_addr_checker.sv
module i2c_addr_checker #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaOe,
  input logic             startDet,
  input logic             stopDet,
  input logic             matchPulse,
  input logic             regSel,
  input logic [REG_W-1:0] regRdata
);
  // R9: acknowledge starts only while SCL is low
  a_r9_ack_start_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> !sclIn);

  // R9: normal release happens only while SCL is low
  a_r9_ack_end_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaOe) && !$past(startDet || stopDet)) |-> !sclIn);

  // R10: the pulse lasts one cycle
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |=> !matchPulse);

  // R10: the pulse comes right after an acknowledge
  a_r10_pulse_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    matchPulse |-> ($past(sdaOe) && !sdaOe));

  // R11: START or STOP releases the bus
  a_r11_abort_release: assert property (@(posedge clk) disable iff (!rstN)
    (startDet || stopDet) |=> !sdaOe);

  // R2: secondary register bit 0 reads as zero
  a_r2_sec_bit0_zero: assert property (@(posedge clk) disable iff (!rstN)
    regSel |-> !regRdata[0]);
endmodule

bind i2c_dual_addr_slave i2c_addr_checker #(.REG_W(ADDR_W + 1)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaOe(sdaOe),
  .startDet(startDet), .stopDet(stopDet), .matchPulse(matchPulse),
  .regSel(regSel), .regRdata(regRdata)
);

// File: tb/i2c_dual_addr_slave_test.sv
module i2c_dual_addr_slave_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaOe, regSel = 1'b0, regWe = 1'b0;
  logic [7:0] regWdata = '0, regRdata;
  logic matchPulse, matchSecondary, matchGenCall, matchRw;
  logic sdaLine;
  int checkCnt = 0, failCnt = 0, pulseCnt = 0;

  always #4 clk = ~clk; // 125 MHz

  assign sdaLine = sdaM & ~sdaOe;

  i2c_dual_addr_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .regSel(regSel), .regWe(regWe), .regWdata(regWdata), .regRdata(regRdata),
    .matchPulse(matchPulse), .matchSecondary(matchSecondary),
    .matchGenCall(matchGenCall), .matchRw(matchRw)
  );

  always @(posedge clk) if (rstN && matchPulse) pulseCnt <= pulseCnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitHalf();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] d);
    @(negedge clk); regSel = sel; regWdata = d; regWe = 1'b1;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic startCond();
    sdaM = 1'b1; waitHalf(); sclM = 1'b1; waitHalf();
    sdaM = 1'b0; waitHalf(); sclM = 1'b0; waitHalf();
  endtask

  task automatic stopCond();
    sdaM = 1'b0; waitHalf(); sclM = 1'b1; waitHalf();
    sdaM = 1'b1; waitHalf();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitHalf(); sclM = 1'b1; waitHalf(); sclM = 1'b0;
    end
  endtask

  task automatic ninthClock(output logic ackLow, output logic ackHigh, output logic rel);
    sdaM = 1'b1; waitHalf(); ackLow = sdaOe;
    sclM = 1'b1; waitHalf(); ackHigh = sdaOe;
    sclM = 1'b0; waitHalf(); rel = sdaOe;
  endtask

  typedef struct packed {
    logic [7:0] pri;
    logic [7:0] sec;
    logic [7:0] addr;
    logic       ack;
    logic       secF;
    logic       gcF;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{8'hA0, 8'h62, 8'hA0, 1'b1, 1'b0, 1'b0}, // R4 primary
    '{8'hA0, 8'h62, 8'hA1, 1'b1, 1'b0, 1'b0}, // R8 rw=1
    '{8'hA0, 8'h62, 8'h63, 1'b1, 1'b1, 1'b0}, // R7 secondary
    '{8'hA0, 8'h62, 8'hA2, 1'b0, 1'b0, 1'b0}, // R4 miss
    '{8'hD1, 8'h40, 8'hDE, 1'b1, 1'b0, 1'b0}, // R5 low bits ignored
    '{8'hD1, 8'h40, 8'hC0, 1'b0, 1'b0, 1'b0}, // R5 upper miss
    '{8'hD1, 8'h40, 8'h00, 1'b1, 1'b0, 1'b1}, // R6 general call
    '{8'hD1, 8'h40, 8'h01, 1'b1, 1'b0, 1'b1}, // R6 general call read
    '{8'hA0, 8'h40, 8'h00, 1'b0, 1'b0, 1'b0}, // R6 not in normal mode
    '{8'hD1, 8'hC4, 8'hC5, 1'b1, 1'b1, 1'b0}, // R7 full compare in expanded
    '{8'hD1, 8'hDA, 8'hDA, 1'b1, 1'b0, 1'b0}, // R7 both hit
    '{8'h21, 8'h22, 8'h2C, 1'b1, 1'b0, 1'b0}, // R5 primary wins
    '{8'hA0, 8'hA4, 8'hA5, 1'b1, 1'b1, 1'b0}  // R7 secondary only
  };

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    logic aL, aH, rel;
    int p0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R3 reset state
    regSel = 1'b0; @(negedge clk); check("R3 primary reset", regRdata, 8'h00);
    regSel = 1'b1; @(negedge clk); check("R3 secondary reset", regRdata, 8'h00);
    check("R3 sdaOe idle", sdaOe, 1'b0);
    check("R10 no pulse after reset", matchPulse, 1'b0);

    // R1 / R2 register port
    writeReg(1'b0, 8'h5B); regSel = 1'b0; @(negedge clk);
    check("R1 primary readback", regRdata, 8'h5B);
    writeReg(1'b1, 8'hFF); regSel = 1'b1; @(negedge clk);
    check("R2 secondary bit0 zero", regRdata, 8'hFE);

    // vector table
    for (int v = 0; v < NV; v++) begin
      writeReg(1'b0, VECS[v].pri);
      writeReg(1'b1, VECS[v].sec);
      p0 = pulseCnt;
      startCond();
      sendBits(VECS[v].addr, 8);
      ninthClock(aL, aH, rel);
      check($sformatf("R9 ack low phase vec %0d", v), aL, VECS[v].ack);
      check($sformatf("R9 ack high phase vec %0d", v), aH, VECS[v].ack);
      check($sformatf("R9 release vec %0d", v), rel, 1'b0);
      check($sformatf("R10 pulse count vec %0d", v), pulseCnt - p0, VECS[v].ack ? 1 : 0);
      if (VECS[v].ack) begin
        check($sformatf("R7 secondary flag vec %0d", v), matchSecondary, VECS[v].secF);
        check($sformatf("R6 gencall flag vec %0d", v), matchGenCall, VECS[v].gcF);
        check($sformatf("R8 rw flag vec %0d", v), matchRw, VECS[v].addr[0]);
      end
      stopCond();
    end

    // R11: STOP mid-address aborts
    writeReg(1'b0, 8'hA0);
    writeReg(1'b1, 8'h10);
    p0 = pulseCnt;
    startCond();
    sendBits(8'hA0, 4);
    sdaM = 1'b0; waitHalf(); sclM = 1'b1; waitHalf(); sdaM = 1'b1; waitHalf();
    sclM = 1'b0; waitHalf();
    sendBits(8'hA0, 4);
    ninthClock(aL, aH, rel);
    check("R11 stop aborts address", aH, 1'b0);
    check("R11 stop no pulse", pulseCnt - p0, 0);
    stopCond();

    // R11: repeated START mid-address restarts collection
    p0 = pulseCnt;
    startCond();
    sendBits(8'hFF, 3);
    startCond();
    sendBits(8'hA1, 8);
    ninthClock(aL, aH, rel);
    check("R11 restart then match ack", aH, 1'b1);
    check("R11 restart pulse", pulseCnt - p0, 1);
    check("R11 restart rw", matchRw, 1'b1);
    stopCond();

    // R12: after a miss, later clocks are ignored
    p0 = pulseCnt;
    startCond();
    sendBits(8'h44, 8);
    ninthClock(aL, aH, rel);
    check("R12 miss no ack", aH, 1'b0);
    sendBits(8'hA0, 8);
    ninthClock(aL, aH, rel);
    check("R12 following byte ignored", aH, 1'b0);
    check("R12 no pulse", pulseCnt - p0, 0);
    check("R10 flags held", matchRw, 1'b1);
    stopCond();

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule